// File: doc/BRIEF.md
# Synthesizer Programmable Divider Chain

This block holds the digital counters that sit around a frequency synthesizer loop. In the reference clock domain, a fixed prescaler turns the reference clock into a narrow compare pulse at one eighth of its rate. In the VCO clock domain, a loadable down-counter divides the VCO clock by a 9-bit loop ratio M and emits a single-cycle feedback pulse. The phase comparator matches this pulse against the reference pulse. With a 2 MHz compare rate, the useful loop ratios run from 200 to 475, and each unit of M moves the VCO by 2 MHz.

A second counter in the VCO domain drives the synthesizer output. It divides the VCO clock by 1, 2, 4 or 8, selected by a 2-bit code, and keeps a 50% duty cycle at every setting. Ratio changes wait for the next wrap of the output counter, so the output never produces a shortened pulse. The loop counter still divides by a ratio outside the useful window, and a flag reports that the latched ratio is out of range. The phase detector, loop filter, oscillator and output buffer are outside this block.

Top module: `synth_div_chain`

## Requirements
- R1: `ref_pulse` is high for exactly one `ref_clk` cycle in every 8 `ref_clk` cycles.
- R2: After reset is released, `ref_pulse` first goes high on the 8th rising `ref_clk` edge and then on every 8th edge after that.
- R3: `fb_pulse` is one `vco_clk` cycle wide. The spacing between two pulses equals the M value captured at the first of the two. The first pulse follows the first rising `vco_clk` edge after reset.
- R4: `m_cfg` is captured only on the edge that raises `fb_pulse`. A new value applied in the middle of a period leaves the current period unchanged and sets the length of the next one.
- R5: `m_range_err` is high exactly when the captured M is below 200 or above 475. It changes only when M is captured. An out-of-range M is still used as the divide ratio.
- R6: A captured M of 0 or 1 gives a feedback period of 2 VCO cycles.
- R7: With the active ratio code 00, `clk_out` follows `vco_clk` directly.
- R8: The active ratio codes 01, 10 and 11 divide `vco_clk` by 2, 4 and 8, each with a 50% duty cycle.
- R9: A new `n_cfg` code becomes active only on the rising `vco_clk` edge where the free-running 3-bit output counter wraps from 7 to 0. Until that edge, the previous ratio stays active.
- R10: During reset, `ref_pulse`, `fb_pulse`, `m_range_err` and `clk_out` are low. After reset, the active ratio is ÷8 until the first output-counter wrap, which occurs on the 8th rising `vco_clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference oscillator clock |
| vco_clk | input | 1 | VCO clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| m_cfg | input | 9 | Loop divide ratio M |
| n_cfg | input | 2 | Output ratio code: 00 ÷1, 01 ÷2, 10 ÷4, 11 ÷8 |
| ref_pulse | output | 1 | Divided reference compare pulse |
| fb_pulse | output | 1 | Loop feedback pulse, once every M VCO cycles |
| m_range_err | output | 1 | Captured M is outside 200..475 |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench changes M in the middle of a feedback period. A design that reloads from the live input would stretch or shorten the period in progress. It also drives the two ends of the 200..475 window and one value just outside each end. A comparator off by one would raise or drop the flag at the wrong value, and the bench checks that counting continues with the out-of-range ratio. The tiny ratios 0 and 1 are covered: a design that wraps the down-counter through all ones would show a 512-cycle period instead of 2. Finally, the bench switches the output ratio just after a wrap and compares every sample of the following eleven VCO cycles. A design that applies the code at once would start toggling seven cycles early and leave a runt high phase.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

   localparam int unsigned ODIV_SEL_W = 2;

   typedef enum logic [ODIV_SEL_W-1:0] {
      ODIV_1 = 2'b00,
      ODIV_2 = 2'b01,
      ODIV_4 = 2'b10,
      ODIV_8 = 2'b11
   } odiv_sel_e;

endpackage

// File: rtl/syn_ref_prescale.sv
module syn_ref_prescale #(
   parameter int unsigned DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse
);
   localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   generate
      if ((1 << CW) == DIV) begin : g_pow2
         // power-of-two ratio: counter wraps naturally
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt <= '0;
            else        cnt <= cnt + 1'b1;
         end
      end else begin : g_modulo
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cnt <= '0;
            else if (cnt == LAST)  cnt <= '0;
            else                   cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= (cnt == LAST);
   end

   // R1: the compare pulse is never wider than one cycle
   p_ref_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R2: no pulse unless the counter was at its last state
   p_ref_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != LAST) |=> !pulse);

endmodule

// File: rtl/syn_fb_div.sv
module syn_fb_div #(
   parameter int unsigned M_W   = 9,
   parameter int unsigned M_MIN = 200,
   parameter int unsigned M_MAX = 475
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] m_cfg,
   output logic           pulse,
   output logic           range_err
);
   localparam logic [M_W-1:0] LO = M_W'(M_MIN);
   localparam logic [M_W-1:0] HI = M_W'(M_MAX);

   logic [M_W-1:0] cnt;
   logic [M_W-1:0] m_lat;
   logic [M_W-1:0] reload_val;
   logic           at_tc;

   assign at_tc = (cnt == '0);

   // ratios below 2 collapse to the shortest legal period of 2
   always_comb begin
      if (m_cfg < M_W'(2)) reload_val = M_W'(1);
      else                 reload_val = m_cfg - M_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         m_lat <= LO;
         pulse <= 1'b0;
      end else if (at_tc) begin
         cnt   <= reload_val;
         m_lat <= m_cfg;
         pulse <= 1'b1;
      end else begin
         cnt   <= cnt - 1'b1;
         pulse <= 1'b0;
      end
   end

   assign range_err = (m_lat < LO) || (m_lat > HI);

   // R3: feedback pulse lasts one cycle
   p_fb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R4: captured ratio moves only at terminal count
   p_mlat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !at_tc |=> $stable(m_lat));

   // R5: the range flag changes only when M is captured
   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !at_tc |=> $stable(range_err));

endmodule

// File: rtl/syn_out_div.sv
module syn_out_div
   import synth_div_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  odiv_sel_e sel_in,
   output logic      clk_out
);
   localparam int unsigned CW = (1 << ODIV_SEL_W) - 1;
   localparam int unsigned NT = 1 << ODIV_SEL_W;

   logic [CW-1:0] cnt;
   logic [NT-1:0] taps;
   odiv_sel_e     sel_q;
   logic          wrap;

   assign wrap = &cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sel_q <= ODIV_8;
      end else begin
         cnt <= cnt + 1'b1;
         if (wrap) sel_q <= sel_in;
      end
   end

   // tap 0 is the undivided clock, tap k is counter bit k-1
   assign taps[0] = clk;
   generate
      for (genvar k = 1; k < NT; k++) begin : g_tap
         assign taps[k] = cnt[k-1];
      end
   endgenerate

   assign clk_out = taps[sel_q];

   // R9: the active ratio changes only at the counter wrap
   p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(sel_q));

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
   import synth_div_pkg::*;
#(
   parameter int unsigned PRE_DIV = 8,
   parameter int unsigned M_W     = 9,
   parameter int unsigned M_MIN   = 200,
   parameter int unsigned M_MAX   = 475
) (
   input  logic                  ref_clk,
   input  logic                  vco_clk,
   input  logic                  rst_n,
   input  logic [M_W-1:0]        m_cfg,
   input  logic [ODIV_SEL_W-1:0] n_cfg,
   output logic                  ref_pulse,
   output logic                  fb_pulse,
   output logic                  m_range_err,
   output logic                  clk_out
);
   generate
      if (PRE_DIV < 2) begin : g_bad_pre
         $error("PRE_DIV must be at least 2");
      end
      if (M_MAX >= (1 << M_W)) begin : g_bad_max
         $error("M_MAX does not fit in M_W bits");
      end
      if (M_MIN > M_MAX) begin : g_bad_win
         $error("M_MIN exceeds M_MAX");
      end
   endgenerate

   odiv_sel_e n_sel;
   assign n_sel = odiv_sel_e'(n_cfg);

   syn_ref_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk   (ref_clk),
      .rst_n (rst_n),
      .pulse (ref_pulse)
   );

   syn_fb_div #(.M_W(M_W), .M_MIN(M_MIN), .M_MAX(M_MAX)) u_fb (
      .clk       (vco_clk),
      .rst_n     (rst_n),
      .m_cfg     (m_cfg),
      .pulse     (fb_pulse),
      .range_err (m_range_err)
   );

   syn_out_div u_odiv (
      .clk     (vco_clk),
      .rst_n   (rst_n),
      .sel_in  (n_sel),
      .clk_out (clk_out)
   );

endmodule

// File: tb/synth_div_chain_tb.sv
`timescale 1ns/100ps
module synth_div_chain_tb;

   logic       ref_clk = 1'b0;
   logic       vco_clk = 1'b0;
   logic       rst_n   = 1'b0;
   logic [8:0] m_cfg   = 9'd200;
   logic [1:0] n_cfg   = 2'b00;
   logic       ref_pulse, fb_pulse, m_range_err, clk_out;

   int n_chk  = 0;
   int n_fail = 0;

   // 250 MHz VCO clock, edges on whole nanoseconds
   always #2 vco_clk = ~vco_clk;
   // reference clock, offset so its edges never meet VCO edges
   initial begin
      #1.5;
      forever #5 ref_clk = ~ref_clk;
   end

   synth_div_chain u_dut (
      .ref_clk     (ref_clk),
      .vco_clk     (vco_clk),
      .rst_n       (rst_n),
      .m_cfg       (m_cfg),
      .n_cfg       (n_cfg),
      .ref_pulse   (ref_pulse),
      .fb_pulse    (fb_pulse),
      .m_range_err (m_range_err),
      .clk_out     (clk_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge ref_clk);
      rst_n = 1'b1;
   endtask

   // counts VCO negedges until fb_pulse is seen high
   task automatic wait_fb(output int gap);
      gap = 0;
      do begin
         @(negedge vco_clk);
         gap++;
      end while (!fb_pulse && gap < 2000);
   endtask

   task automatic t_reset();
      m_cfg = 9'd200;
      n_cfg = 2'b00;
      rst_n = 1'b0;
      repeat (3) @(negedge ref_clk);
      chk(!ref_pulse && !fb_pulse && !m_range_err && !clk_out, "R10 reset outputs",
          {ref_pulse, fb_pulse, m_range_err, clk_out}, 0);
      @(negedge ref_clk);
      rst_n = 1'b1;
      @(posedge vco_clk);
      @(negedge vco_clk);
      chk(fb_pulse == 1'b1, "R3 first pulse after reset", fb_pulse, 1);
      chk(m_range_err == 1'b0, "R5 flag low for M=200", m_range_err, 0);
      chk(clk_out == 1'b0, "R10 div8 phase k=1", clk_out, 0);
      for (int k = 2; k <= 7; k++) begin
         @(posedge vco_clk);
         @(negedge vco_clk);
         chk(clk_out == ((k >> 2) & 1), "R10 div8 after reset", clk_out, (k >> 2) & 1);
      end
      @(posedge vco_clk);
      @(negedge vco_clk);
      #1 chk(clk_out == 1'b0, "R7 div1 low phase", clk_out, 0);
      @(posedge vco_clk);
      #1 chk(clk_out == 1'b1, "R7 div1 high phase", clk_out, 1);
   endtask

   task automatic t_ref();
      int bad = 0;
      int first = 0;
      do_reset();
      for (int i = 1; i <= 40; i++) begin
         @(negedge ref_clk);
         if (ref_pulse && first == 0) first = i;
         if (ref_pulse != (i % 8 == 0)) bad++;
      end
      chk(first == 8, "R2 first reference pulse", first, 8);
      chk(bad == 0, "R1 one pulse every 8 cycles", bad, 0);
   endtask

   task automatic t_fb(input int m, input int exp_gap, input bit exp_flag);
      int gap;
      m_cfg = 9'(m);
      wait_fb(gap);
      wait_fb(gap);
      chk(m_range_err == exp_flag, m < 2 ? "R6 flag" : "R5 range flag", m_range_err, exp_flag);
      wait_fb(gap);
      chk(gap == exp_gap, m < 2 ? "R6 small ratio period" : "R3 feedback period", gap, exp_gap);
   endtask

   task automatic t_m_change();
      int gap;
      m_cfg = 9'd210;
      wait_fb(gap);
      wait_fb(gap);
      m_cfg = 9'd230;
      wait_fb(gap);
      chk(gap == 210, "R4 period in progress keeps old M", gap, 210);
      wait_fb(gap);
      chk(gap == 230, "R4 next period uses new M", gap, 230);
   endtask

   task automatic t_ratio(input logic [1:0] code, input int h);
      logic s[32];
      int bad = 0;
      int highs = 0;
      n_cfg = code;
      repeat (24) @(negedge vco_clk);
      for (int i = 0; i < 32; i++) begin
         @(negedge vco_clk);
         s[i] = clk_out;
         if (clk_out) highs++;
      end
      for (int i = 0; i + h < 32; i++) if (s[i] == s[i + h]) bad++;
      chk(bad == 0, "R8 half-period pattern", bad, 0);
      chk(highs == 16, "R8 50% duty", highs, 16);
   endtask

   task automatic t_switch();
      int exp_v[11] = '{0, 0, 0, 1, 1, 1, 1, 0, 1, 0, 1};
      logic prev;
      int guard = 0;
      int bad = 0;
      n_cfg = 2'b11;
      repeat (24) @(negedge vco_clk);
      prev = clk_out;
      do begin
         @(negedge vco_clk);
         guard++;
         if (prev && !clk_out) break;
         prev = clk_out;
      end while (guard < 40);
      n_cfg = 2'b01;
      for (int i = 0; i < 11; i++) begin
         @(negedge vco_clk);
         if (clk_out != exp_v[i]) begin
            bad++;
            $display("FAIL R9 sample %0d actual=%0d expected=%0d", i, clk_out, exp_v[i]);
         end
      end
      n_chk++;
      if (bad != 0) n_fail++;
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_ref();
      t_fb(200, 200, 1'b0);
      t_fb(475, 475, 1'b0);
      t_fb(199, 199, 1'b1);
      t_fb(476, 476, 1'b1);
      t_fb(1, 2, 1'b1);
      t_fb(0, 2, 1'b1);
      t_m_change();
      t_ratio(2'b01, 1);
      t_ratio(2'b10, 2);
      t_ratio(2'b11, 4);
      t_switch();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule